// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block derives an audio sample strobe from a fast module clock. The average spacing between strobes is a rational number of clock cycles, N/(M+1). N and M come packed in one 32-bit control word. Each individual interval is a whole number of cycles. The mix of short and long intervals is arranged so that the long-run rate matches the programmed ratio exactly. The strobe paces a serial audio sample bus downstream. Crossing into another clock domain and handling of sample data are outside this block.

A small state machine has two states. `DIV_IDLE` is the disabled state. It holds the accumulator at zero and keeps the strobe low. `DIV_RUN` accumulates on every clock. The state machine has four transitions:
- `IDLE->IDLE` while the enable is low.
- `IDLE->RUN` on the first clock with the enable high. On this clock the control word is captured.
- `RUN->RUN` while the enable stays high. On each such clock the accumulator adds M+1 and, on reaching N, subtracts N and emits a strobe.
- `RUN->IDLE` on any clock with the enable low. This clears the accumulator.

Top module: `smp_rate_gen`

## Requirements
- R1: While reset is asserted, and after it is released with the enable low, `smp_stb` is 0.
- R2: N is `ctrl_word[31:8]` and M is `ctrl_word[7:0]`. The programmed ratio is N/(M+1).
- R3: In `DIV_RUN` with the enable high, each clock adds M+1 to the accumulator. When the sum is at least N, N is subtracted and `smp_stb` is 1 in the following cycle. Otherwise `smp_stb` is 0 in the following cycle.
- R4: When N ≥ M+1, every interval between two consecutive strobes is floor(N/(M+1)) or ceil(N/(M+1)) clock cycles.
- R5: When N ≥ M+1, exactly M+1 strobes are emitted over the first N accumulating clocks after capture.
- R6: When N is 0 or N < M+1, the effective N becomes M+1. The block then strobes on every accumulating clock, never more than once per clock.
- R7: With the enable low, `smp_stb` is 0 from the next clock onward and the accumulator is zeroed. After re-enabling, the first strobe arrives at the same cycle as after a fresh start.
- R8: The control word is captured only on the `IDLE->RUN` transition. Changes while running have no effect on the strobe pattern.
- R9: The capturing clock emits no strobe. The first strobe appears ceil(N_eff/(M+1)) clocks after the capturing clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the accumulator |
| ctrl_word | input | 32 | N in bits 31:8, M in bits 7:0 |
| smp_stb | output | 1 | One-cycle sample strobe |

## Verification
The bench builds the block with its default widths: a 24-bit numerator and an 8-bit denominator term. With these widths the bench can reach the largest step of 256 (M = 255) next to a numerator three times that size, and it can reach a non-integer ratio near 142.9 over a full window of N clocks. The bench also exercises the clamp cases (N of zero, and N below M+1), a live rewrite of the control word during a run, and a stop followed by a restart that shows the cleared accumulator.

// File: rtl/smp_div_pkg.sv
package smp_div_pkg;

    localparam int unsigned DEF_NUM_W = 24;
    localparam int unsigned DEF_DEN_W = 8;

    typedef enum logic [0:0] {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/smp_div_cfg.sv
module smp_div_cfg
    import smp_div_pkg::*;
#(
    parameter int unsigned NUM_W = DEF_NUM_W,
    parameter int unsigned DEN_W = DEF_DEN_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [NUM_W+DEN_W-1:0] ctrl_word,
    output logic [DEN_W:0]         step_q,
    output logic [NUM_W-1:0]       neff_q
);

    localparam int unsigned STEP_W = DEN_W + 1;

    logic [NUM_W-1:0]  num_field;
    logic [DEN_W-1:0]  den_field;
    logic [STEP_W-1:0] step_d;
    logic [NUM_W-1:0]  step_ext;
    logic [NUM_W-1:0]  neff_d;

    assign num_field = ctrl_word[NUM_W+DEN_W-1:DEN_W];
    assign den_field = ctrl_word[DEN_W-1:0];

    always_comb begin
        step_d   = {1'b0, den_field} + {{DEN_W{1'b0}}, 1'b1};
        step_ext = {{(NUM_W-STEP_W){1'b0}}, step_d};
        // a numerator below the step would ask for several strobes per clock
        if (num_field < step_ext) begin
            neff_d = step_ext;
        end else begin
            neff_d = num_field;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= {{DEN_W{1'b0}}, 1'b1};
            neff_q <= {{(NUM_W-1){1'b0}}, 1'b1};
        end else if (load) begin
            step_q <= step_d;
            neff_q <= neff_d;
        end
    end

endmodule

// File: rtl/smp_div_accum.sv
module smp_div_accum
    import smp_div_pkg::*;
#(
    parameter int unsigned NUM_W = DEF_NUM_W,
    parameter int unsigned DEN_W = DEF_DEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [DEN_W:0]   step_q,
    input  logic [NUM_W-1:0] neff_q,
    output logic [NUM_W-1:0] acc_q,
    output logic             wrap
);

    localparam int unsigned SUM_W = NUM_W + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] neff_ext;
    logic [SUM_W-1:0] remain;
    logic [NUM_W-1:0] acc_d;

    always_comb begin
        sum      = {1'b0, acc_q} + {{(SUM_W-DEN_W-1){1'b0}}, step_q};
        neff_ext = {1'b0, neff_q};
        wrap     = (sum >= neff_ext);
        remain   = sum - neff_ext;
        if (wrap) begin
            acc_d = remain[NUM_W-1:0];
        end else begin
            acc_d = sum[NUM_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (advance) begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/smp_div_fsm.sv
module smp_div_fsm
    import smp_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       wrap,
    output div_state_e state_q,
    output logic       load,
    output logic       clear,
    output logic       advance,
    output logic       smp_stb
);

    div_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        clear   = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            DIV_IDLE: begin
                clear = 1'b1;
                if (en) begin
                    load    = 1'b1;
                    state_d = DIV_RUN;
                end
            end
            DIV_RUN: begin
                if (en) begin
                    advance = 1'b1;
                end else begin
                    clear   = 1'b1;
                    state_d = DIV_IDLE;
                end
            end
            default: begin
                clear   = 1'b1;
                state_d = DIV_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_stb <= 1'b0;
        end else begin
            smp_stb <= advance & wrap;
        end
    end

endmodule

// File: rtl/smp_rate_gen.sv
module smp_rate_gen
    import smp_div_pkg::*;
#(
    parameter int unsigned NUM_W = DEF_NUM_W,
    parameter int unsigned DEN_W = DEF_DEN_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [NUM_W+DEN_W-1:0] ctrl_word,
    output logic                   smp_stb
);

    div_state_e       state_q;
    logic             load;
    logic             clear;
    logic             advance;
    logic             wrap;
    logic [DEN_W:0]   step_q;
    logic [NUM_W-1:0] neff_q;
    logic [NUM_W-1:0] acc_q;

    smp_div_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wrap    (wrap),
        .state_q (state_q),
        .load    (load),
        .clear   (clear),
        .advance (advance),
        .smp_stb (smp_stb)
    );

    smp_div_cfg #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ctrl_word (ctrl_word),
        .step_q    (step_q),
        .neff_q    (neff_q)
    );

    smp_div_accum #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .advance (advance),
        .step_q  (step_q),
        .neff_q  (neff_q),
        .acc_q   (acc_q),
        .wrap    (wrap)
    );

endmodule

// File: rtl/smp_rate_gen_chk.sv
module smp_rate_gen_chk
    import smp_div_pkg::*;
#(
    parameter int unsigned NUM_W = DEF_NUM_W,
    parameter int unsigned DEN_W = DEF_DEN_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             smp_stb,
    input div_state_e       state_q,
    input logic [DEN_W:0]   step_q,
    input logic [NUM_W-1:0] neff_q,
    input logic [NUM_W-1:0] acc_q
);

    logic [NUM_W-1:0] step_wide;
    assign step_wide = {{(NUM_W-DEN_W-1){1'b0}}, step_q};

    // R7: a low enable silences the strobe on the next clock
    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !smp_stb);

    // R3: the running remainder always stays below the effective numerator
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_RUN) |-> (acc_q < neff_q));

    // R6: a clamped ratio strobes on every accumulating clock
    p_clamp_every_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_RUN && en && neff_q == step_wide) |=> smp_stb);

    // R8: captured configuration holds for the whole run
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_RUN && en) |=> ($stable(neff_q) && $stable(step_q)));

    // R9: the capturing clock never strobes
    p_capture_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_IDLE && en) |=> !smp_stb);

endmodule

bind smp_rate_gen smp_rate_gen_chk #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .smp_stb (smp_stb),
    .state_q (state_q),
    .step_q  (step_q),
    .neff_q  (neff_q),
    .acc_q   (acc_q)
);

// File: tb/sim_smp_rate_gen.sv
module sim_smp_rate_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] ctrl = 32'd0;
    logic        smp_stb;

    always #10 clk = ~clk;

    smp_rate_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ctrl_word (ctrl),
        .smp_stb   (smp_stb)
    );

    // behavioural reference model
    int   m_acc = 0;
    int   m_step = 1;
    int   m_neff = 1;
    bit   m_run = 0;
    logic exp_stb = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_acc = 0; exp_stb = 1'b0;
        end else if (!en) begin
            m_run = 0; m_acc = 0; exp_stb = 1'b0;
        end else if (!m_run) begin
            m_run  = 1;
            m_acc  = 0;
            m_step = int'(ctrl[7:0]) + 1;
            m_neff = int'(ctrl[31:8]);
            if (m_neff < m_step) m_neff = m_step;
            exp_stb = 1'b0;
        end else begin
            m_acc = m_acc + m_step;
            if (m_acc >= m_neff) begin
                m_acc = m_acc - m_neff;
                exp_stb = 1'b1;
            end else begin
                exp_stb = 1'b0;
            end
        end
    end

    int    n_checks = 0;
    int    n_errs = 0;
    string tag = "R1";
    int    since_en = 0;
    int    stb_cnt = 0;
    int    first_at = 0;
    int    gap = 0;
    bit    have_prev = 0;
    bit    gap_on = 0;
    int    gap_lo = 0;
    int    gap_hi = 0;
    bit    done = 0;

    task automatic chk(input string t, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_errs++;
            $display("FAIL %s actual %0d expected %0d", t, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        n_checks++;
        if (smp_stb !== exp_stb) begin
            n_errs++;
            $display("FAIL %s strobe actual %0b expected %0b", tag, smp_stb, exp_stb);
        end
        since_en++;
        gap++;
        if (smp_stb === 1'b1) begin
            stb_cnt++;
            if (first_at == 0) first_at = since_en;
            if (gap_on && have_prev) begin
                n_checks++;
                if (gap != gap_lo && gap != gap_hi) begin
                    n_errs++;
                    $display("FAIL R4 interval actual %0d expected %0d or %0d", gap, gap_lo, gap_hi);
                end
            end
            have_prev = 1;
            gap = 0;
        end
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    task automatic restart_counters();
        since_en = 0; stb_cnt = 0; first_at = 0; gap = 0; have_prev = 0;
    endtask

    task automatic start(input logic [23:0] nv, input logic [7:0] mv, input bit gaps);
        int step;
        en = 1'b0;
        ticks(2);
        ctrl = {nv, mv};
        en = 1'b1;
        step = int'(mv) + 1;
        gap_on = gaps;
        gap_lo = int'(nv) / step;
        gap_hi = (int'(nv) + step - 1) / step;
        restart_counters();
    endtask

    initial begin
        // R1: reset holds the strobe low
        tag = "R1";
        ticks(3);
        chk("R1", int'(smp_stb), 0);
        rst_n = 1'b1;
        ticks(3);
        chk("R1", int'(smp_stb), 0);

        // R3 and R4: non-integer ratio 10/3
        tag = "R3";
        start(24'd10, 8'd2, 1'b1);
        ticks(300);
        chk("R3", stb_cnt, 89);

        // R5 and R9: ratio 1000/7 over a full window of N clocks
        tag = "R5";
        start(24'd1000, 8'd6, 1'b1);
        ticks(1001);
        chk("R5", stb_cnt, 7);
        chk("R9", first_at, 144);

        // R2: largest step, period exactly three
        tag = "R2";
        start(24'd768, 8'hFF, 1'b1);
        ticks(31);
        chk("R2", first_at, 4);
        chk("R2", stb_cnt, 10);

        // R6: clamp with N of zero and with N below M+1
        tag = "R6";
        start(24'd0, 8'd5, 1'b0);
        ticks(51);
        chk("R6", stb_cnt, 50);
        start(24'd3, 8'd9, 1'b0);
        ticks(41);
        chk("R6", stb_cnt, 40);

        // R8: live rewrite of the control word is ignored
        tag = "R8";
        start(24'd20, 8'd0, 1'b1);
        ticks(5);
        ctrl = {24'd2, 8'd0};
        ticks(100);
        chk("R8", stb_cnt, 5);

        // R7: disable clears the accumulator, restart matches a fresh start
        tag = "R7";
        start(24'd10, 8'd2, 1'b1);
        ticks(7);
        en = 1'b0;
        tick();
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R7", int'(smp_stb), 0);
        end
        ctrl = {24'd10, 8'd2};
        en = 1'b1;
        restart_counters();
        ticks(20);
        chk("R7", first_at, 5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

endmodule